// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single DMA channel that moves data between system memory and one peripheral FIFO. It owns two buffer slots, A and B, each with a start address and a byte count. While one slot drains, software refills the other, and the channel moves from one to the next with no idle cycle in between. A completion flag is raised for each slot, a misplaced peripheral request is flagged as an error, and an interrupt line reports either condition.

Software reaches the channel through a 32-byte register window. One control/status byte has three views. Writing ones at the set view turns bits on. Writing ones at the clear view turns bits off. The read view returns the live value. A configuration word selects the direction, the byte order, the burst length, the beat width and the peripheral. The same word also carries a packed peripheral address, which the block unpacks onto a port.

Each peripheral request grants a burst of beats, one per cycle. In each beat the channel performs one memory access at the current address of the active slot and hands one data word to or from the peripheral.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset the status byte, the configuration word and both slots read as zero, and `irq` is low.
- R2: The status byte reads at offset 0x0C. Ones written at offset 0x04 set bits and ones written at 0x08 clear bits; zero bits have no effect. Bit 0 is run, bit 1 is interrupt enable, bit 2 is error, bit 3 is A done, bit 4 is A started, bit 5 is B done, bit 6 is B started and bit 7 selects the active slot (1 = B).
- R3: Slot A start and count are at 0x10 and 0x14, and slot B start and count are at 0x18 and 0x1C. A start address keeps bits 31:2 with its two low bits reading zero. A count keeps its low 13 bits (at most 0x1FFF). Both read back live as the transfer advances.
- R4: The configuration word at 0x00 drives `per_dev_addr` = {cfg[31:28], 6'b0, cfg[27:8], 2'b00} and `per_sel` = cfg[7:4].
- R5: A request accepted while the channel is active starts a burst of 4 beats (cfg[2]=0) or 8 beats (cfg[2]=1), one beat per cycle. Each beat advances the address and lowers the count by 1 byte (cfg[3]=0) or 2 bytes (cfg[3]=1). cfg[0]=1 writes peripheral data to memory and cfg[0]=0 reads memory for the peripheral. A request made during a burst is ignored.
- R6: In 16-bit mode with cfg[1]=1 (big-endian) the two bytes are swapped on the way through; with cfg[1]=0 they pass unchanged. In 8-bit mode only the low byte is carried.
- R7: When the active slot's count reaches zero, the channel clears that slot's start bit, sets its done bit and toggles bit 7. If the other slot is started, beats continue there in the next cycle and the running burst carries on.
- R8: With run set and no slot started, and no request made, the channel makes no beat and leaves the error bit clear.
- R9: A request made while no transfer is active (run clear, or the active slot not started) sets the error bit and clears run, and no beat is made.
- R10: Clearing run pauses the channel with address and count held. Setting run again resumes from that point.
- R11: `irq` is high exactly when interrupt enable is set and any of error, A done or B done is set. Writing those three bits at the clear view drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset inside the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| per_req | input | 1 | Peripheral burst request |
| per_ack | output | 1 | Beat taken this cycle |
| per_rdata | input | 16 | Data from the peripheral |
| per_wdata | output | 16 | Data to the peripheral |
| per_dev_addr | output | 32 | Unpacked peripheral address |
| per_sel | output | 4 | Peripheral select code |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read) |
| mem_wide | output | 1 | Access is 2 bytes (else 1) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a burst that crosses from one slot into the other on consecutive cycles. It only happens when a slot's count runs out partway through a granted burst while the other slot is already started. The stimulus loads slot A with 3 bytes and slot B with 5, starts both, and makes a single 8-beat request. It then measures the longest unbroken run of beats and the address sequence, which must jump from A's range to B's range with no gap. The pause and resume case is also deliberate: it stops the channel halfway through a slot and checks that the held count and address carry on after run is set again.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

   // register window offsets
   localparam logic [4:0] OFF_CFG     = 5'h00;
   localparam logic [4:0] OFF_SET     = 5'h04;
   localparam logic [4:0] OFF_CLR     = 5'h08;
   localparam logic [4:0] OFF_READ    = 5'h0C;
   localparam logic [4:0] OFF_A_START = 5'h10;
   localparam logic [4:0] OFF_A_COUNT = 5'h14;
   localparam logic [4:0] OFF_B_START = 5'h18;
   localparam logic [4:0] OFF_B_COUNT = 5'h1C;

   // status byte bit positions
   localparam int B_RUN   = 0;
   localparam int B_IE    = 1;
   localparam int B_ERR   = 2;
   localparam int B_DONEA = 3;
   localparam int B_STRTA = 4;
   localparam int B_DONEB = 5;
   localparam int B_STRTB = 6;
   localparam int B_BIU   = 7;

   typedef struct packed {
      logic [3:0]  hi;      // peripheral address bits 31:28
      logic [19:0] mid;     // peripheral address bits 21:2
      logic [3:0]  sel;     // peripheral select
      logic        wide;    // 16-bit beats
      logic        burst8;  // 8-beat bursts
      logic        big;     // big-endian byte order
      logic        to_mem;  // peripheral -> memory
   } cfg_t;

endpackage

// File: rtl/pp_dma_slot.sv
module pp_dma_slot #(
   parameter int         ADDR_W    = 32,
   parameter int         CNT_W     = 13,
   parameter logic [4:0] OFF_START = 5'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [31:0]       wdata,
   input  logic              beat,
   input  logic [1:0]        step,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              last,
   output logic              empty
);
   localparam logic [4:0] OFF_COUNT = OFF_START + 5'd4;

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      last  = cnt_q <= CNT_W'(step);
      empty = cnt_q == '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (beat) begin
            addr_q <= addr_q + ADDR_W'(step);
            cnt_q  <= last ? '0 : cnt_q - CNT_W'(step);
         end
         // software write takes priority over the beat update
         if (wr_en && wr_addr == OFF_START) addr_q <= {wdata[ADDR_W-1:2], 2'b00};
         if (wr_en && wr_addr == OFF_COUNT) cnt_q  <= wdata[CNT_W-1:0];
      end
   end

   assign addr = addr_q;
   assign cnt  = cnt_q;
endmodule

// File: rtl/pp_dma_lane.sv
module pp_dma_lane #(
   parameter int DATA_W = 16
) (
   input  logic              wide,
   input  logic              big,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] swapped;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("pp_dma_lane: DATA_W must be a multiple of 8, at least 16");
      end
      for (genvar b = 0; b < NB; b++) begin : g_swap
         assign swapped[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
      end
   endgenerate

   always_comb begin
      if (!wide)    dout = DATA_W'(din[7:0]);
      else if (big) dout = swapped;
      else          dout = din;
   end
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
   import pp_dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 13,
   parameter int DATA_W      = 16,
   parameter int BURST_SHORT = 4,
   parameter int BURST_LONG  = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [4:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        per_req,
   output logic        per_ack,
   input  logic [15:0] per_rdata,
   output logic [15:0] per_wdata,
   output logic [31:0] per_dev_addr,
   output logic [3:0]  per_sel,
   output logic        mem_en,
   output logic        mem_we,
   output logic        mem_wide,
   output logic [31:0] mem_addr,
   output logic [15:0] mem_wdata,
   input  logic [15:0] mem_rdata,
   output logic        irq
);
   localparam int NSLOT = 2;
   localparam int BL_W  = $clog2(BURST_LONG + 1);

   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("pp_dma_channel: the packed peripheral address needs ADDR_W == 32");
      end
      if (DATA_W != 16) begin : g_bad_data
         $error("pp_dma_channel: port widths assume DATA_W == 16");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("pp_dma_channel: CNT_W out of range");
      end
      if (BURST_SHORT < 1 || BURST_LONG <= BURST_SHORT) begin : g_bad_burst
         $error("pp_dma_channel: burst lengths must satisfy 0 < SHORT < LONG");
      end
   endgenerate

   logic [31:0]       cfg_q;
   cfg_t              c;
   logic [7:0]        st_q, st_hw, st_d;
   logic [BL_W-1:0]   burst_q, burst_d, burst_len;
   logic [ADDR_W-1:0] s_addr  [NSLOT];
   logic [CNT_W-1:0]  s_cnt   [NSLOT];
   logic              s_last  [NSLOT];
   logic              s_empty [NSLOT];
   logic              cur, cur_start, active, beat, finish, accept, fault;
   logic              set_wr, clr_wr;
   logic [1:0]        step;

   assign c         = cfg_t'(cfg_q);
   assign step      = c.wide ? 2'd2 : 2'd1;
   assign burst_len = c.burst8 ? BL_W'(BURST_LONG) : BL_W'(BURST_SHORT);
   assign set_wr    = reg_we && reg_addr == OFF_SET;
   assign clr_wr    = reg_we && reg_addr == OFF_CLR;

   // ---------------- buffer slots ----------------
   generate
      for (genvar i = 0; i < NSLOT; i++) begin : g_slot
         pp_dma_slot #(
            .ADDR_W   (ADDR_W),
            .CNT_W    (CNT_W),
            .OFF_START(i == 0 ? OFF_A_START : OFF_B_START)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_we),
            .wr_addr(reg_addr),
            .wdata  (reg_wdata),
            .beat   (beat && (cur == 1'(i))),
            .step   (step),
            .addr   (s_addr[i]),
            .cnt    (s_cnt[i]),
            .last   (s_last[i]),
            .empty  (s_empty[i])
         );
      end
   endgenerate

   // ---------------- sequencing ----------------
   assign cur       = st_q[B_BIU];
   assign cur_start = cur ? st_q[B_STRTB] : st_q[B_STRTA];
   assign active    = st_q[B_RUN] && cur_start;
   assign beat      = active && (burst_q != '0) && !s_empty[cur];
   assign finish    = active && (s_empty[cur] || (beat && s_last[cur]));
   assign accept    = per_req && active && (burst_q == '0);
   assign fault     = per_req && !active;

   always_comb begin
      st_hw = st_q;
      if (finish) begin
         if (cur) begin
            st_hw[B_STRTB] = 1'b0;
            st_hw[B_DONEB] = 1'b1;
         end else begin
            st_hw[B_STRTA] = 1'b0;
            st_hw[B_DONEA] = 1'b1;
         end
         st_hw[B_BIU] = ~cur;
      end
      if (fault) begin
         st_hw[B_ERR] = 1'b1;
         st_hw[B_RUN] = 1'b0;
      end
      st_d = st_hw;
      if (set_wr) st_d = st_d | reg_wdata[7:0];
      if (clr_wr) st_d = st_d & ~reg_wdata[7:0];
   end

   always_comb begin
      if (!active)     burst_d = '0;
      else if (accept) burst_d = burst_len;
      else if (beat)   burst_d = burst_q - BL_W'(1);
      else             burst_d = burst_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= '0;
         burst_q <= '0;
         cfg_q   <= '0;
      end else begin
         st_q    <= st_d;
         burst_q <= burst_d;
         if (reg_we && reg_addr == OFF_CFG) cfg_q <= reg_wdata;
      end
   end

   // ---------------- register read ----------------
   always_comb begin
      case (reg_addr)
         OFF_CFG:     reg_rdata = cfg_q;
         OFF_READ:    reg_rdata = {24'h0, st_q};
         OFF_A_START: reg_rdata = 32'(s_addr[0]);
         OFF_A_COUNT: reg_rdata = 32'(s_cnt[0]);
         OFF_B_START: reg_rdata = 32'(s_addr[1]);
         OFF_B_COUNT: reg_rdata = 32'(s_cnt[1]);
         default:     reg_rdata = '0;
      endcase
   end

   // ---------------- data path ----------------
   pp_dma_lane #(.DATA_W(DATA_W)) u_lane_to_mem (
      .wide(c.wide), .big(c.big), .din(per_rdata), .dout(mem_wdata)
   );
   pp_dma_lane #(.DATA_W(DATA_W)) u_lane_to_per (
      .wide(c.wide), .big(c.big), .din(mem_rdata), .dout(per_wdata)
   );

   assign per_ack      = beat;
   assign mem_en       = beat;
   assign mem_we       = beat && c.to_mem;
   assign mem_wide     = c.wide;
   assign mem_addr     = s_addr[cur];
   assign per_dev_addr = {c.hi, 6'b000000, c.mid, 2'b00};
   assign per_sel      = c.sel;
   assign irq          = st_q[B_IE] && (st_q[B_ERR] || st_q[B_DONEA] || st_q[B_DONEB]);
endmodule

// File: rtl/pp_dma_channel_chk.sv
module pp_dma_channel_chk
   import pp_dma_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [4:0] reg_addr,
   input logic [7:0] wd,
   input logic [7:0] st,
   input logic       per_ack,
   input logic       irq
);
   logic sw_wr;
   assign sw_wr = reg_we && (reg_addr == OFF_SET || reg_addr == OFF_CLR);

   // R2: set and clear views act on the status byte
   a_r2_set_view: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFF_SET) |=> ((st & $past(wd)) == $past(wd)));
   a_r2_clr_view: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFF_CLR) |=> ((st & $past(wd)) == 8'h00));

   // R5: a beat happens only while run and the active slot is started
   a_r5_beat_when_active: assert property (@(posedge clk) disable iff (!rst_n)
      per_ack |-> (st[B_RUN] && (st[B_BIU] ? st[B_STRTB] : st[B_STRTA])));

   // R7: hardware completion of A also swaps the active slot
   a_r7_done_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st[B_DONEA]) && !$past(sw_wr)) |-> (st[B_BIU] != $past(st[B_BIU])));

   // R8: no started slot, no beat
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!st[B_STRTA] && !st[B_STRTB]) |-> !per_ack);

   // R9: a hardware-raised error leaves run clear
   a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st[B_ERR]) && !$past(sw_wr)) |-> !st[B_RUN]);

   // R11: acknowledging all three sources drops the interrupt
   a_r11_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFF_CLR && wd[B_ERR] && wd[B_DONEA] && wd[B_DONEB]) |=> !irq);
endmodule

bind pp_dma_channel pp_dma_channel_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_we  (reg_we),
   .reg_addr(reg_addr),
   .wd      (reg_wdata[7:0]),
   .st      (st_q),
   .per_ack (per_ack),
   .irq     (irq)
);

// File: tb/pp_dma_channel_tb.sv
module pp_dma_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        per_req = 1'b0;
   logic        per_ack;
   logic [15:0] per_rdata;
   logic [15:0] per_wdata;
   logic [31:0] per_dev_addr;
   logic [3:0]  per_sel;
   logic        mem_en, mem_we, mem_wide;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        irq;

   logic [7:0]  pd = 8'h00;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   int          n_ack;
   int          max_run;
   logic [31:0] cap_addr [16];
   logic [15:0] cap_mw   [16];
   logic [15:0] cap_pw   [16];
   logic [7:0]  cap_pd   [16];
   logic        cap_we   [16];
   logic        cap_wide [16];

   always #5 clk = ~clk;

   function automatic logic [7:0] pat(input logic [7:0] a);
      return a ^ 8'h5A;
   endfunction

   assign per_rdata = {pd ^ 8'hF0, pd};
   assign mem_rdata = {pat(mem_addr[7:0] + 8'd1), pat(mem_addr[7:0])};

   pp_dma_channel u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
      .per_ack(per_ack), .per_rdata(per_rdata), .per_wdata(per_wdata),
      .per_dev_addr(per_dev_addr), .per_sel(per_sel), .mem_en(mem_en),
      .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   // raise per_req for 'hold' cycles and watch 'cycles' negedges
   task automatic run_req(input int hold, input int cycles);
      int run_now;
      run_now = 0; n_ack = 0; max_run = 0;
      @(negedge clk);
      per_req = (hold > 0);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (per_ack) begin
            if (n_ack < 16) begin
               cap_addr[n_ack] = mem_addr;  cap_mw[n_ack] = mem_wdata;
               cap_pw[n_ack]   = per_wdata; cap_pd[n_ack] = pd;
               cap_we[n_ack]   = mem_we;    cap_wide[n_ack] = mem_wide;
            end
            n_ack++; run_now++;
            if (run_now > max_run) max_run = run_now;
            pd = pd + 8'd1;
         end else run_now = 0;
         if (i == hold - 1) per_req = 1'b0;
      end
      per_req = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(5'h0C, v); check("R1 status", v, 32'h0);
      rd(5'h00, v); check("R1 cfg", v, 32'h0);
      rd(5'h14, v); check("R1 countA", v, 32'h0);
      rd(5'h18, v); check("R1 startB", v, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_setclr;
      logic [31:0] v;
      wr(5'h04, 32'h03); rd(5'h0C, v); check("R2 set", v, 32'h03);
      wr(5'h04, 32'h00); rd(5'h0C, v); check("R2 zero set", v, 32'h03);
      wr(5'h08, 32'h02); rd(5'h0C, v); check("R2 clear", v, 32'h01);
      // run with nothing started: idle, no error
      run_req(0, 8);
      check("R8 no beats", 32'(n_ack), 32'h0);
      rd(5'h0C, v); check("R8 no error", v, 32'h01);
      wr(5'h08, 32'hFF); rd(5'h0C, v); check("R2 clear all", v, 32'h0);
   endtask

   task automatic t_bufregs;
      logic [31:0] v;
      wr(5'h10, 32'h0000_1003); rd(5'h10, v); check("R3 A start aligned", v, 32'h0000_1000);
      wr(5'h14, 32'h0000_FFFF); rd(5'h14, v); check("R3 A count masked", v, 32'h0000_1FFF);
      wr(5'h18, 32'hDEAD_BEEF); rd(5'h18, v); check("R3 B start aligned", v, 32'hDEAD_BEEC);
      wr(5'h1C, 32'h0000_0123); rd(5'h1C, v); check("R3 B count", v, 32'h0000_0123);
   endtask

   task automatic t_cfg;
      wr(5'h00, 32'hA123_45F6);
      check("R4 dev addr", per_dev_addr, 32'hA004_8D14);
      check("R4 select", 32'(per_sel), 32'hF);
   endtask

   task automatic t_rx8;
      logic [31:0] v;
      logic [7:0]  p0;
      wr(5'h00, 32'h01);          // to memory, 4-beat, 8-bit
      wr(5'h10, 32'h40); wr(5'h14, 32'd6);
      wr(5'h04, 32'h13);          // RUN|IE|STRTA
      p0 = pd;
      run_req(3, 10);             // held 3 cycles: extra requests ignored
      check("R5 burst of 4", 32'(n_ack), 32'd4);
      for (int k = 0; k < 4; k++) begin
         check("R5 rx addr", cap_addr[k], 32'h40 + 32'(k));
         check("R5 rx write", 32'(cap_we[k]), 32'h1);
         check("R6 8-bit low byte", 32'(cap_mw[k]), {24'h0, p0 + 8'(k)});
      end
      rd(5'h0C, v); check("R5 no error on held req", v, 32'h13);
      run_req(1, 8);
      check("R7 remaining beats", 32'(n_ack), 32'd2);
      rd(5'h0C, v); check("R7 A done, B active", v, 32'h8B);
      rd(5'h14, v); check("R3 live count", v, 32'h0);
      rd(5'h10, v); check("R3 live address", v, 32'h46);
      check("R11 irq on done", 32'(irq), 32'h1);
      wr(5'h08, 32'h2C);
      check("R11 irq acked", 32'(irq), 32'h0);
      wr(5'h08, 32'h51);          // stop: run and both starts
      rd(5'h0C, v); check("R2 stop", v, 32'h82);
   endtask

   task automatic t_seamless;
      logic [31:0] v;
      wr(5'h08, 32'h80);          // back to slot A
      wr(5'h00, 32'h04);          // from memory, 8-beat, 8-bit
      wr(5'h10, 32'h80); wr(5'h14, 32'd3);
      wr(5'h18, 32'hC0); wr(5'h1C, 32'd5);
      wr(5'h04, 32'h51);
      run_req(1, 14);
      check("R5 burst of 8", 32'(n_ack), 32'd8);
      check("R7 no gap across slots", 32'(max_run), 32'd8);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] ea;
         ea = (k < 3) ? 32'h80 + 32'(k) : 32'hC0 + 32'(k - 3);
         check("R7 slot address", cap_addr[k], ea);
         check("R5 tx data", 32'(cap_pw[k]), {24'h0, pat(ea[7:0])});
      end
      rd(5'h0C, v); check("R7 both done", v, 32'h2B);
   endtask

   task automatic t_wide;
      logic [31:0] v;
      logic [7:0]  p0;
      wr(5'h08, 32'hFF);
      wr(5'h00, 32'h0B);          // to memory, big-endian, 16-bit
      wr(5'h10, 32'h20); wr(5'h14, 32'd4);
      wr(5'h04, 32'h11);
      p0 = pd;
      run_req(1, 8);
      check("R5 16-bit beats", 32'(n_ack), 32'd2);
      for (int k = 0; k < 2; k++) begin
         logic [7:0] q;
         q = p0 + 8'(k);
         check("R5 wide step", cap_addr[k], 32'h20 + 32'(2 * k));
         check("R5 wide flag", 32'(cap_wide[k]), 32'h1);
         check("R6 big swap", 32'(cap_mw[k]), {16'h0, q, q ^ 8'hF0});
      end
      rd(5'h0C, v); check("R7 wide done", v, 32'h89);
      wr(5'h08, 32'hFF);
      wr(5'h00, 32'h08);          // from memory, little-endian, 16-bit
      wr(5'h10, 32'h30); wr(5'h14, 32'd2);
      wr(5'h04, 32'h11);
      run_req(1, 6);
      check("R5 single wide beat", 32'(n_ack), 32'd1);
      check("R6 little passes", 32'(cap_pw[0]), {16'h0, pat(8'h31), pat(8'h30)});
   endtask

   task automatic t_pause;
      logic [31:0] v;
      wr(5'h08, 32'hFF);
      wr(5'h00, 32'h01);
      wr(5'h10, 32'h50); wr(5'h14, 32'd8);
      wr(5'h04, 32'h11);
      run_req(1, 8);
      check("R10 first half", 32'(n_ack), 32'd4);
      wr(5'h08, 32'h01);          // pause
      run_req(0, 6);
      check("R10 paused no beat", 32'(n_ack), 32'd0);
      rd(5'h14, v); check("R10 count held", v, 32'd4);
      rd(5'h10, v); check("R10 address held", v, 32'h54);
      wr(5'h04, 32'h01);          // resume
      run_req(1, 8);
      check("R10 resumed beats", 32'(n_ack), 32'd4);
      check("R10 resumed address", cap_addr[0], 32'h54);
      rd(5'h0C, v); check("R10 done after resume", v, 32'h89);
   endtask

   task automatic t_error;
      logic [31:0] v;
      wr(5'h08, 32'hFF);
      wr(5'h04, 32'h03);          // RUN|IE, nothing started
      run_req(1, 4);
      check("R9 no beat on fault", 32'(n_ack), 32'd0);
      rd(5'h0C, v); check("R9 error and stop", v, 32'h06);
      check("R11 irq on error", 32'(irq), 32'h1);
      wr(5'h08, 32'h2C);
      check("R11 error acked", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setclr();
      t_bufregs();
      t_cfg();
      t_rx8();
      t_seamless();
      t_wide();
      t_pause();
      t_error();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule